// File: doc/BRIEF.md
# Three-Input Integer Add Unit

This unit is the execute stage for a three-input integer add. Each issued operation supplies three 32-bit operands, a form select (register, constant or immediate) and a set of modifiers. The unit adds the three operands with two's-complement wraparound and returns the sum one cycle later, together with a valid strobe.

In register form each operand can first be narrowed to its low or high halfword, and the partial sum of the first two operands can be moved by 16 bits in either direction before the third operand is added. Each operand can also be negated individually. The narrowing happens before the negation. An illegal halfword code in register form suppresses the result: the unit returns zero and raises an unsupported flag. Constant and immediate forms ignore the halfword and shift fields entirely.

Top module: `tri_add_unit`

## Requirements
- R1: In constant form (`formSel`=1) and immediate form (`formSel`=2), with no negation, `sumOut` equals opA+opB+opC modulo 2^32.
- R2: When a negate bit is set (`negMask` bit 0 for A, bit 1 for B, bit 2 for C), that operand is replaced by its two's-complement negation before any addition. Negating 0x80000000 gives 0x80000000.
- R3: In register form (`formSel`=0), a halfword code of 0 passes the operand unchanged, 1 keeps bits 15:0 with the upper bits cleared, and 2 moves bits 31:16 down to bits 15:0 with the upper bits cleared. The codes are `halfA`, `halfB` and `halfC`.
- R4: In register form the halfword narrowing is applied before the negation.
- R5: In register form the 32-bit A+B partial sum, with any carry out of bit 31 dropped, is shifted by `shiftMode` before C is added: 1 is a logical right shift by 16, 2 is a logical left shift by 16, and 0 or 3 leaves it unshifted.
- R6: In constant form, immediate form and the reserved form value 3, the halfword codes and `shiftMode` have no effect and `unsupportedOut` stays 0.
- R7: In register form, a halfword code of 3 on any operand makes `sumOut` 0 and `unsupportedOut` 1 for that operation. Otherwise `unsupportedOut` is 0. Whenever `unsupportedOut` is 1, `sumOut` is 0.
- R8: `outValid` is high exactly one cycle after a cycle with `inValid` high, and low otherwise. A synchronous reset clears `outValid`, `sumOut` and `unsupportedOut`.
- R9: In a cycle with `inValid` low, `sumOut` and `unsupportedOut` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation present on the inputs this cycle |
| formSel | input | 2 | 0 register, 1 constant, 2 immediate, 3 reserved |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opC | input | 32 | Third operand |
| halfA | input | 2 | Halfword code for A |
| halfB | input | 2 | Halfword code for B |
| halfC | input | 2 | Halfword code for C |
| negMask | input | 3 | Negate bits: bit 0 A, bit 1 B, bit 2 C |
| shiftMode | input | 2 | Partial-sum shift: 0 none, 1 right 16, 2 left 16, 3 none |
| outValid | output | 1 | Result valid, one cycle after inValid |
| sumOut | output | 32 | Registered result |
| unsupportedOut | output | 1 | Illegal halfword code seen in register form |

## Verification
The operand modifiers (narrowing, negation, partial-sum shift) and the illegal-code suppression can all act on the same operation. The bench provokes this by sweeping every form, every combination of the three halfword codes, every negate mask and every shift code, so an illegal code often arrives together with a shift and negations. Each result is judged against a reference model written from the requirements, in which suppression wins in register form and has no effect in the other forms.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;

  localparam int NUM_OPS = 3;

  typedef enum logic [1:0] {
    FORM_REG   = 2'd0,
    FORM_CONST = 2'd1,
    FORM_IMM   = 2'd2,
    FORM_RSVD  = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    HALF_FULL = 2'd0,
    HALF_LOW  = 2'd1,
    HALF_HIGH = 2'd2,
    HALF_BAD  = 2'd3
  } half_e;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_RIGHT = 2'd1,
    SHIFT_LEFT  = 2'd2,
    SHIFT_KEEP  = 2'd3
  } shift_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new result
    logic useHalf;  // apply halfword codes
    logic shRight;  // shift A+B right
    logic shLeft;   // shift A+B left
    logic zeroOut;  // suppress result, flag unsupported
  } ctl_t;

endpackage

// File: rtl/tri_add_ctrl.sv
module tri_add_ctrl
  import tri_add_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [1:0]              formSel,
  input  logic [NUM_OPS-1:0][1:0] halfVec,
  input  logic [1:0]              shiftMode,
  output ctl_t                    ctl,
  output logic                    outValid
);

  logic isReg;
  logic badHalf;

  always_comb begin
    isReg   = (formSel == FORM_REG);
    badHalf = 1'b0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (halfVec[i] == HALF_BAD) badHalf = 1'b1;
    end
  end

  always_comb begin
    ctl.load    = inValid;
    ctl.useHalf = isReg;
    ctl.shRight = isReg && (shiftMode == SHIFT_RIGHT);
    ctl.shLeft  = isReg && (shiftMode == SHIFT_LEFT);
    ctl.zeroOut = isReg && badHalf;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R8: valid follows the accepted operation by one cycle
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/tri_add_dp.sv
module tri_add_dp
  import tri_add_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctl_t                    ctl,
  input  logic [NUM_OPS-1:0][W-1:0] opVec,
  input  logic [NUM_OPS-1:0][1:0] halfVec,
  input  logic [NUM_OPS-1:0]      negVec,
  output logic [W-1:0]            result,
  output logic                    unsupported
);

  localparam int HALF = W / 2;

  logic [NUM_OPS-1:0][W-1:0] condOp;
  logic [W-1:0] pairSum;
  logic [W-1:0] shiftedSum;
  logic [W-1:0] total;

  // Per-operand conditioning: narrow first, then negate
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic [W-1:0] cut;
    always_comb begin
      cut = opVec[i];
      if (ctl.useHalf) begin
        case (halfVec[i])
          HALF_LOW:  cut = {{(W-HALF){1'b0}}, opVec[i][HALF-1:0]};
          HALF_HIGH: cut = {{(W-HALF){1'b0}}, opVec[i][W-1:HALF]};
          HALF_BAD:  cut = '0;
          default:   cut = opVec[i];
        endcase
      end
    end
    assign condOp[i] = negVec[i] ? -cut : cut;
  end

  always_comb begin
    pairSum = condOp[0] + condOp[1];
    if (ctl.shRight)     shiftedSum = pairSum >> HALF;
    else if (ctl.shLeft) shiftedSum = pairSum << HALF;
    else                 shiftedSum = pairSum;
    total = shiftedSum + condOp[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      unsupported <= 1'b0;
    end else if (ctl.load) begin
      result      <= ctl.zeroOut ? '0 : total;
      unsupported <= ctl.zeroOut;
    end
  end

  // R9: no load, no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> ($stable(result) && $stable(unsupported)));
  // R7: flagged results are zero
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> (result == '0));
  // R6: forms without halfword handling never flag
  assert_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !ctl.useHalf) |=> !unsupported);

endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [1:0]   formSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [1:0]   halfA,
  input  logic [1:0]   halfB,
  input  logic [1:0]   halfC,
  input  logic [2:0]   negMask,
  input  logic [1:0]   shiftMode,
  output logic         outValid,
  output logic [W-1:0] sumOut,
  output logic         unsupportedOut
);

  ctl_t ctl;
  logic [NUM_OPS-1:0][W-1:0] opVec;
  logic [NUM_OPS-1:0][1:0]   halfVec;

  assign opVec   = {opC, opB, opA};
  assign halfVec = {halfC, halfB, halfA};

  tri_add_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .formSel   (formSel),
    .halfVec   (halfVec),
    .shiftMode (shiftMode),
    .ctl       (ctl),
    .outValid  (outValid)
  );

  tri_add_dp #(.W(W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .opVec       (opVec),
    .halfVec     (halfVec),
    .negVec      (negMask),
    .result      (sumOut),
    .unsupported (unsupportedOut)
  );

endmodule

// File: tb/tri_add_unit_bench.sv
module tri_add_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [1:0]  form;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [5:0]  half;   // {C,B,A}
    logic [2:0]  neg;
    logic [1:0]  sh;
    logic [31:0] expRes;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TABLE [NVEC] = '{
    // R1 wraparound, constant form
    '{2'd1, 32'hFFFFFFFF, 32'h2, 32'h0, 6'd0, 3'b000, 2'd0, 32'h1, 1'b0},
    // R2 negate the most negative value, immediate form
    '{2'd2, 32'h80000000, 32'h0, 32'h0, 6'd0, 3'b001, 2'd0, 32'h80000000, 1'b0},
    // R4 narrow low half of A then negate
    '{2'd0, 32'h00010003, 32'h0, 32'h0, 6'b000001, 3'b001, 2'd0, 32'hFFFFFFFD, 1'b0},
    // R5 right shift, carry out of A+B dropped
    '{2'd0, 32'hFFFF0000, 32'h00020000, 32'h5, 6'd0, 3'b000, 2'd1, 32'h6, 1'b0},
    // R5 left shift
    '{2'd0, 32'h1234, 32'h1, 32'h1, 6'd0, 3'b000, 2'd2, 32'h12350001, 1'b0},
    // R3 A high half, B low half, C full
    '{2'd0, 32'hABCD1234, 32'h0000FFFF, 32'h11112222, 6'b000110, 3'b000, 2'd0, 32'h1112CDEE, 1'b0},
    // R6 immediate form ignores illegal codes and shift
    '{2'd2, 32'h1, 32'h2, 32'h3, 6'b111111, 3'b000, 2'd1, 32'h6, 1'b0},
    // R7 illegal code on C in register form
    '{2'd0, 32'h5, 32'h0, 32'h0, 6'b110000, 3'b000, 2'd0, 32'h0, 1'b1},
    // R6 reserved form ignores halfword and shift
    '{2'd3, 32'h00010000, 32'h0, 32'h1, 6'b000001, 3'b000, 2'd2, 32'h00010001, 1'b0},
    // R5 shift code 3 leaves the sum alone
    '{2'd0, 32'h10, 32'h20, 32'h1, 6'd0, 3'b000, 2'd3, 32'h31, 1'b0},
    // R2 all three negated
    '{2'd1, 32'h1, 32'h2, 32'h3, 6'd0, 3'b111, 2'd0, 32'hFFFFFFFA, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  formSel = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic [1:0]  halfA = '0, halfB = '0, halfC = '0;
  logic [2:0]  negMask = '0;
  logic [1:0]  shiftMode = '0;
  logic        outValid;
  logic [31:0] sumOut;
  logic        unsupportedOut;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_add_unit u_tri_add_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .formSel(formSel),
    .opA(opA), .opB(opB), .opC(opC),
    .halfA(halfA), .halfB(halfB), .halfC(halfC),
    .negMask(negMask), .shiftMode(shiftMode),
    .outValid(outValid), .sumOut(sumOut), .unsupportedOut(unsupportedOut)
  );

  // Reference model written from the requirements
  function automatic logic [32:0] refModel(input logic [1:0] form,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
      input logic [5:0] half, input logic [2:0] neg, input logic [1:0] sh);
    logic [31:0] ops [3];
    logic [31:0] s;
    logic err;
    ops[0] = a; ops[1] = b; ops[2] = c;
    err = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (form == 2'd0) begin
        case (half[2*i +: 2])
          2'd1: ops[i] = ops[i] & 32'h0000FFFF;
          2'd2: ops[i] = ops[i] >> 16;
          2'd3: begin ops[i] = 32'h0; err = 1'b1; end
          default: ;
        endcase
      end
      if (neg[i]) ops[i] = 32'h0 - ops[i];
    end
    s = ops[0] + ops[1];
    if (form == 2'd0 && sh == 2'd1) s = s >> 16;
    if (form == 2'd0 && sh == 2'd2) s = s << 16;
    s = s + ops[2];
    if (err) s = 32'h0;
    return {err, s};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] form, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input logic [5:0] half,
      input logic [2:0] neg, input logic [1:0] sh,
      input logic [31:0] expRes, input logic expErr, input string req);
    @(negedge clk);
    inValid = 1'b1; formSel = form; opA = a; opB = b; opC = c;
    halfA = half[1:0]; halfB = half[3:2]; halfC = half[5:4];
    negMask = neg; shiftMode = sh;
    @(negedge clk);
    check(outValid === 1'b1 && sumOut === expRes && unsupportedOut === expErr,
          req, {31'd0, outValid, sumOut}, {31'd1, expErr, expRes});
    inValid = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        nFail++;
        nChecks++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    logic [32:0] r;
    logic [31:0] holdVal;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(outValid === 1'b0 && sumOut === 32'h0 && unsupportedOut === 1'b0, "R8 reset",
          {31'd0, unsupportedOut, sumOut}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid === 1'b0, "R8 idle", {63'd0, outValid}, 64'd0);

    for (int k = 0; k < NVEC; k++) begin
      apply(TABLE[k].form, TABLE[k].a, TABLE[k].b, TABLE[k].c, TABLE[k].half,
            TABLE[k].neg, TABLE[k].sh, TABLE[k].expRes, TABLE[k].expErr, "table R1-vector");
    end

    // Full sweep of form, halfword codes, negates and shift against the model (R1..R7)
    for (int f = 0; f < 4; f++) begin
      for (int h = 0; h < 64; h++) begin
        for (int n = 0; n < 8; n++) begin
          for (int s = 0; s < 4; s++) begin
            logic [31:0] a, b, c;
            int idx;
            idx = ((f * 64 + h) * 8 + n) * 4 + s;
            a = 32'h9E3779B9 * (idx + 1);
            b = 32'h7F4A7C15 ^ (a << 3);
            c = 32'hC2B2AE35 + (a >> 5);
            if (idx % 17 == 0) a = 32'h80000000;
            if (idx % 23 == 0) b = 32'hFFFFFFFF;
            r = refModel(f[1:0], a, b, c, h[5:0], n[2:0], s[1:0]);
            apply(f[1:0], a, b, c, h[5:0], n[2:0], s[1:0], r[31:0], r[32], "sweep R3 R5 R7");
          end
        end
      end
    end

    // R9: inputs change with inValid low, outputs hold
    apply(2'd1, 32'h100, 32'h20, 32'h3, 6'd0, 3'b000, 2'd0, 32'h123, 1'b0, "R1 setup");
    holdVal = sumOut;
    @(negedge clk);
    opA = 32'hDEADBEEF; formSel = 2'd0; halfA = 2'd3; shiftMode = 2'd2;
    @(negedge clk);
    check(outValid === 1'b0 && sumOut === holdVal && unsupportedOut === 1'b0, "R9 hold",
          {31'd0, unsupportedOut, sumOut}, {32'd0, holdVal});

    // R8: reset with inValid high clears everything
    @(negedge clk);
    inValid = 1'b1; rst = 1'b1; formSel = 2'd1; opA = 32'h55;
    @(negedge clk);
    check(outValid === 1'b0 && sumOut === 32'h0 && unsupportedOut === 1'b0, "R8 reset wins",
          {31'd0, outValid, sumOut}, 64'd0);
    inValid = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule